// File: doc/BRIEF.md
# Dual-Issue In-Order Pairing Logic

This block sits between an in-order instruction queue and two parallel execution pipes. On every clock it looks at the two entries at the head of the queue: the older one and the younger one. It decides whether both can leave together or only the older one. When they leave together, the older entry goes to pipe A and the younger entry to pipe B.

The only pairing rule is a register dependency check. The younger entry is held back if it reads or writes the register that the older entry writes. Register 0 is excluded from this check, because writes to it are discarded. A held-back entry is never moved ahead of, or around, the older one. It stays at the queue head and is offered again on the next cycle.

The queue learns how many head entries it should pop through a combinational consumed count. The count is valid in the same cycle as the slot inputs. The pipe outputs are registered and carry the issued fields one clock later. A downstream stall freezes issue completely.

Top module: `dual_pair_issue`

## Requirements
- R1: After a synchronous reset, pipe A and pipe B both present valid low.
- R2: With no stall, both slots valid and no dependency, take_cnt is 2 in that cycle. On the next clock, pipe A carries the older slot and pipe B the younger slot, both valid.
- R3: If the older slot writes a nonzero register that the younger slot reads as its first or second source, take_cnt is 1. On the next clock, only pipe A is valid and it carries the older slot.
- R4: If both slots write the same nonzero destination register, only the older slot issues and take_cnt is 1.
- R5: An older destination of register 0 never creates a dependency. Slots that match only through register 0 issue as a pair with take_cnt 2.
- R6: While stall is high, take_cnt is 0 and both pipes present valid low on the next clock, whatever the slot contents.
- R7: When only the older slot is valid, take_cnt is 1 and it issues alone to pipe A.
- R8: When the older slot is invalid, nothing issues and take_cnt is 0, even if the younger slot is valid.
- R9: At most two entries issue per cycle. Pipe B is never valid unless pipe A is valid in the same cycle.
- R10: Issued opcode class, destination and source fields appear unchanged on the pipe outputs one clock after the decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Downstream stall; blocks all issue |
| old_vld | input | 1 | Older head slot valid |
| old_opc | input | OPC_W | Older slot opcode class |
| old_dst | input | REG_W | Older slot destination register |
| old_src0 | input | REG_W | Older slot first source register |
| old_src1 | input | REG_W | Older slot second source register |
| yng_vld | input | 1 | Younger head slot valid |
| yng_opc | input | OPC_W | Younger slot opcode class |
| yng_dst | input | REG_W | Younger slot destination register |
| yng_src0 | input | REG_W | Younger slot first source register |
| yng_src1 | input | REG_W | Younger slot second source register |
| take_cnt | output | 2 | Entries consumed this cycle (0, 1 or 2) |
| pa_vld | output | 1 | Pipe A valid |
| pa_opc | output | OPC_W | Pipe A opcode class |
| pa_dst | output | REG_W | Pipe A destination register |
| pa_src0 | output | REG_W | Pipe A first source register |
| pa_src1 | output | REG_W | Pipe A second source register |
| pb_vld | output | 1 | Pipe B valid |
| pb_opc | output | OPC_W | Pipe B opcode class |
| pb_dst | output | REG_W | Pipe B destination register |
| pb_src0 | output | REG_W | Pipe B first source register |
| pb_src1 | output | REG_W | Pipe B second source register |

## Verification
The assertions assume the slot inputs and stall are stable across each rising edge, and that the queue presents its entries in program order. This means a valid younger slot always belongs directly after the older one. The bench drives every input on the falling edge and holds it through the following rising edge. It reads the combinational count before that edge and the pipe outputs after it. Each scenario offers slot pairs that a real in-order queue could present, including the case of a younger entry valid behind an empty older slot, to confirm that nothing jumps ahead.

// File: rtl/pair_pkg.sv
package pair_pkg;
    parameter int REG_W = 5;
    parameter int OPC_W = 3;
    parameter int NUM_SRC = 2;
    localparam int PIPES = 2;
    localparam int CNT_W = $clog2(PIPES + 1);

    typedef struct packed {
        logic             vld;
        logic [OPC_W-1:0] opc;
        logic [REG_W-1:0] dst;
        logic [REG_W-1:0] src1;
        logic [REG_W-1:0] src0;
    } slot_t;

    function automatic logic writes_reg(slot_t s);
        return s.vld && (s.dst != '0);
    endfunction

    function automatic logic [REG_W-1:0] src_sel(slot_t s, int idx);
        return (idx == 0) ? s.src0 : s.src1;
    endfunction
endpackage

// File: rtl/pair_hazard.sv
module pair_hazard
    import pair_pkg::*;
(
    input  slot_t older,
    input  slot_t younger,
    output logic  raw_hit,
    output logic  waw_hit
);
    logic [NUM_SRC-1:0] src_match;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign src_match[g] = writes_reg(older) && younger.vld &&
                              (src_sel(younger, g) == older.dst);
    end

    assign raw_hit = |src_match;
    assign waw_hit = writes_reg(older) && younger.vld && (younger.dst == older.dst);
endmodule

// File: rtl/pair_decide.sv
module pair_decide
    import pair_pkg::*;
(
    input  logic             stall,
    input  logic             old_ok,
    input  logic             yng_ok,
    input  logic             raw_hit,
    input  logic             waw_hit,
    output logic             issue_a,
    output logic             issue_b,
    output logic [CNT_W-1:0] take_cnt
);
    always_comb begin
        issue_a  = 1'b0;
        issue_b  = 1'b0;
        take_cnt = '0;
        if (!stall && old_ok) begin
            issue_a = 1'b1;
            issue_b = yng_ok && !raw_hit && !waw_hit;
            take_cnt = issue_b ? CNT_W'(2) : CNT_W'(1);
        end
    end
endmodule

// File: rtl/pipe_latch.sv
module pipe_latch
    import pair_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  issue,
    input  slot_t din,
    output slot_t q
);
    always_ff @(posedge clk) begin
        if (rst || !issue) begin
            q <= '0;
        end else begin
            q     <= din;
            q.vld <= 1'b1;
        end
    end
endmodule

// File: rtl/dual_pair_issue.sv
module dual_pair_issue
    import pair_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             stall,
    input  logic             old_vld,
    input  logic [OPC_W-1:0] old_opc,
    input  logic [REG_W-1:0] old_dst,
    input  logic [REG_W-1:0] old_src0,
    input  logic [REG_W-1:0] old_src1,
    input  logic             yng_vld,
    input  logic [OPC_W-1:0] yng_opc,
    input  logic [REG_W-1:0] yng_dst,
    input  logic [REG_W-1:0] yng_src0,
    input  logic [REG_W-1:0] yng_src1,
    output logic [1:0]       take_cnt,
    output logic             pa_vld,
    output logic [OPC_W-1:0] pa_opc,
    output logic [REG_W-1:0] pa_dst,
    output logic [REG_W-1:0] pa_src0,
    output logic [REG_W-1:0] pa_src1,
    output logic             pb_vld,
    output logic [OPC_W-1:0] pb_opc,
    output logic [REG_W-1:0] pb_dst,
    output logic [REG_W-1:0] pb_src0,
    output logic [REG_W-1:0] pb_src1
);
    slot_t            slots  [PIPES];
    slot_t            pipe_q [PIPES];
    logic [PIPES-1:0] issue;
    logic             raw_hit, waw_hit;
    logic [CNT_W-1:0] cnt;

    assign slots[0] = '{vld: old_vld, opc: old_opc, dst: old_dst, src1: old_src1, src0: old_src0};
    assign slots[1] = '{vld: yng_vld, opc: yng_opc, dst: yng_dst, src1: yng_src1, src0: yng_src0};

    pair_hazard u_haz (
        .older   (slots[0]),
        .younger (slots[1]),
        .raw_hit (raw_hit),
        .waw_hit (waw_hit)
    );

    pair_decide u_dec (
        .stall    (stall),
        .old_ok   (old_vld),
        .yng_ok   (yng_vld),
        .raw_hit  (raw_hit),
        .waw_hit  (waw_hit),
        .issue_a  (issue[0]),
        .issue_b  (issue[1]),
        .take_cnt (cnt)
    );

    for (genvar p = 0; p < PIPES; p++) begin : g_pipe
        pipe_latch u_lat (
            .clk   (clk),
            .rst   (rst),
            .issue (issue[p]),
            .din   (slots[p]),
            .q     (pipe_q[p])
        );
    end

    assign take_cnt = 2'(cnt);
    assign pa_vld   = pipe_q[0].vld;
    assign pa_opc   = pipe_q[0].opc;
    assign pa_dst   = pipe_q[0].dst;
    assign pa_src0  = pipe_q[0].src0;
    assign pa_src1  = pipe_q[0].src1;
    assign pb_vld   = pipe_q[1].vld;
    assign pb_opc   = pipe_q[1].opc;
    assign pb_dst   = pipe_q[1].dst;
    assign pb_src0  = pipe_q[1].src0;
    assign pb_src1  = pipe_q[1].src1;

    // R9: pipe B never runs without pipe A
    a_r9_b_needs_a: assert property (@(posedge clk) disable iff (rst) pb_vld |-> pa_vld);
    // R6: a stall empties both pipes on the following clock
    a_r6_stall_idle: assert property (@(posedge clk) disable iff (rst)
        stall |=> (!pa_vld && !pb_vld));
    // R3: a read-after-write pair consumes one entry only
    a_r3_dep_single: assert property (@(posedge clk) disable iff (rst)
        (raw_hit && old_vld && !stall) |-> (take_cnt == 2'd1));
    // R8: nothing moves while the older slot is empty
    a_r8_no_older: assert property (@(posedge clk) disable iff (rst)
        !old_vld |-> (take_cnt == 2'd0));
    // R2: pipe B is filled exactly when two entries were consumed
    a_r2_pair_fill: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (pb_vld == ($past(take_cnt) == 2'd2)));
    // R9: count never exceeds the number of pipes
    a_r9_cnt_range: assert property (@(posedge clk) disable iff (rst) take_cnt != 2'd3);
endmodule

// File: tb/sim_dual_pair_issue.sv
`timescale 1ns/1ps
module sim_dual_pair_issue;
    import pair_pkg::*;

    logic clk = 1'b0;
    logic rst;
    logic stall;
    logic old_vld, yng_vld;
    logic [OPC_W-1:0] old_opc, yng_opc;
    logic [REG_W-1:0] old_dst, old_src0, old_src1;
    logic [REG_W-1:0] yng_dst, yng_src0, yng_src1;
    logic [1:0]       take_cnt;
    logic             pa_vld, pb_vld;
    logic [OPC_W-1:0] pa_opc, pb_opc;
    logic [REG_W-1:0] pa_dst, pa_src0, pa_src1, pb_dst, pb_src0, pb_src1;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    dual_pair_issue u0 (.*);

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(logic sv, logic ov, int oo, int od, int os0, int os1,
                         logic yv, int yo, int yd, int ys0, int ys1);
        @(negedge clk);
        stall = sv;
        old_vld = ov; old_opc = OPC_W'(oo); old_dst = REG_W'(od);
        old_src0 = REG_W'(os0); old_src1 = REG_W'(os1);
        yng_vld = yv; yng_opc = OPC_W'(yo); yng_dst = REG_W'(yd);
        yng_src0 = REG_W'(ys0); yng_src1 = REG_W'(ys1);
    endtask

    // check count now, then pipes after the next edge
    task automatic step(string req, int exp_cnt, logic exp_a, logic exp_b);
        logic [OPC_W-1:0] oo, yo;
        logic [REG_W-1:0] od, os0, os1, yd, ys0, ys1;
        #1;
        chk({req, " take_cnt"}, take_cnt, exp_cnt);
        oo = old_opc; od = old_dst; os0 = old_src0; os1 = old_src1;
        yo = yng_opc; yd = yng_dst; ys0 = yng_src0; ys1 = yng_src1;
        @(posedge clk); #1;
        chk({req, " pa_vld"}, pa_vld, exp_a);
        chk({req, " pb_vld"}, pb_vld, exp_b);
        if (exp_a) begin
            chk({req, "/R10 pa_opc"}, pa_opc, oo);
            chk({req, "/R10 pa_dst"}, pa_dst, od);
            chk({req, "/R10 pa_src0"}, pa_src0, os0);
            chk({req, "/R10 pa_src1"}, pa_src1, os1);
        end
        if (exp_b) begin
            chk({req, "/R10 pb_opc"}, pb_opc, yo);
            chk({req, "/R10 pb_dst"}, pb_dst, yd);
            chk({req, "/R10 pb_src0"}, pb_src0, ys0);
            chk({req, "/R10 pb_src1"}, pb_src1, ys1);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        drive(0, 1, 1, 3, 4, 5, 1, 2, 6, 7, 8);
        repeat (2) @(posedge clk);
        #1;
        chk("R1 pa_vld", pa_vld, 0);
        chk("R1 pb_vld", pb_vld, 0);
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic t_pair();
        drive(0, 1, 1, 3, 4, 5, 1, 2, 6, 7, 8);
        step("R2 independent", 2, 1, 1);
        drive(0, 1, 5, 9, 9, 9, 1, 6, 10, 11, 12);
        step("R2 self-read older", 2, 1, 1);
    endtask

    task automatic t_raw();
        drive(0, 1, 1, 7, 1, 2, 1, 3, 8, 7, 4);
        step("R3 src0 dep", 1, 1, 0);
        drive(0, 1, 2, 12, 1, 2, 1, 4, 9, 3, 12);
        step("R3 src1 dep", 1, 1, 0);
        // dependent entry re-offered at the head next cycle
        drive(0, 1, 4, 9, 3, 12, 1, 1, 13, 14, 15);
        step("R3 requeued head", 2, 1, 1);
    endtask

    task automatic t_waw();
        drive(0, 1, 1, 20, 1, 2, 1, 2, 20, 3, 4);
        step("R4 same dst", 1, 1, 0);
    endtask

    task automatic t_zero();
        drive(0, 1, 1, 0, 1, 2, 1, 2, 0, 0, 0);
        step("R5 reg0", 2, 1, 1);
    endtask

    task automatic t_stall();
        drive(1, 1, 1, 3, 4, 5, 1, 2, 6, 7, 8);
        step("R6 stall", 0, 0, 0);
        drive(1, 1, 1, 7, 1, 2, 0, 0, 0, 0, 0);
        step("R6 stall single", 0, 0, 0);
    endtask

    task automatic t_lone();
        drive(0, 1, 6, 17, 18, 19, 0, 0, 0, 0, 0);
        step("R7 lone older", 1, 1, 0);
    endtask

    task automatic t_noold();
        drive(0, 0, 1, 3, 4, 5, 1, 2, 6, 7, 8);
        step("R8 no older", 0, 0, 0);
    endtask

    task automatic t_limit();
        drive(0, 1, 7, 31, 30, 29, 1, 7, 28, 27, 26);
        step("R9 max two", 2, 1, 1);
        chk("R9 count bound", int'(take_cnt <= 2'd2), 1);
    endtask

    initial begin
        t_reset();
        t_pair();
        t_raw();
        t_waw();
        t_zero();
        t_stall();
        t_lone();
        t_noold();
        t_limit();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule